// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block drives synchronous burst reads out of a 2M-word by 16-bit storage array. A host starts a burst by pulling the active-low address strobe while the active-low chip select is asserted. The block latches the start address, waits a programmable number of clock cycles, and then presents one word per clock at consecutive addresses. A ready output marks each cycle that carries a valid word. Ready drops for one cycle whenever the sequencer inserts an extra latency cycle.

The array sits behind a plain synchronous-read port. The sequencer raises a read request with an address, and the array returns the word on the next clock. That word goes straight to the data output. A small write-only configuration port sets the initial latency and turns on a power-save mode. Power-save mode costs two extra cycles at the start of every burst.

A burst runs until chip select is released, the synchronous reset is applied, or a new address strobe restarts it. Internal stalls come from three sources: the fixed 64-word block boundaries, the wrap from the top of the array back to zero, and the power-save startup cycles.

Top module: `burst_seq_top`

## Requirements
- R1: After reset, ready and the read request are low, the latency setting is 7 cycles, and power-save mode is off.
- R2: A clock edge that samples the address strobe low while chip select is low latches the start address. The first word, read from that address, is presented with ready high N edges later, where N is the latency setting (plus one when power-save is on). Ready stays low from that edge until then.
- R3: After the first word, the following words come from consecutive addresses, one per clock, with ready high.
- R4: After a word whose address has its low six bits equal to 3Fh is presented, ready is low for exactly one cycle before the next word.
- R5: The word after address 1FFFFFh comes from address 000000h. That step also carries the R4 stall.
- R6: A configuration write to select 0 with a value from 4 to 7 sets the latency setting. A write there of a value from 0 to 3 is ignored, and the previous setting is kept.
- R7: A configuration write to select 1 with data bit 0 set turns power-save on. A write with bit 0 clear is ignored, and only reset turns the mode off. With power-save on, one ready-low cycle also separates the first and second words of a burst. When that stall coincides with an R4 stall, only one cycle is inserted.
- R8: Chip select sampled high at an edge ends the burst, and ready is low from that edge on. An address strobe sampled while chip select is high starts nothing.
- R9: An address strobe during a running burst restarts it at the new address with the full latency counted from that strobe.
- R10: Configuration writes during a burst, including writes to select 2 (the reset command) and select 3, do not alter that burst. Latency and power-save values are taken at each strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en_n | input | 1 | Chip select, active low |
| addr_strobe_n | input | 1 | Address-valid strobe, active low |
| addr_in | input | 21 | Burst start address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration select: 0 latency, 1 power-save, 2 reset command, 3 unused |
| cfg_wdata | input | 3 | Configuration write data |
| mem_rd | output | 1 | Array read request |
| mem_addr | output | 21 | Array read address |
| mem_rdata | input | 16 | Array read data, valid one clock after the request |
| rdy | output | 1 | High in each cycle that presents a valid word |
| dout | output | 16 | Burst data word |

## Verification
Every expected value is tied to a cycle index counted from the edge that samples the strobe.

The first word is due exactly N edges after the strobe edge, where N is the latency setting plus any power-save cycle. Each later word is due one edge after the previous one, plus one more edge for each stall from R4 or R7. A deselect shows as ready low right after the edge that samples it. A configuration write affects only the latency of the next strobe.

The driver computes each burst's cycle-by-cycle ready and data pattern when it drives the strobe, and queues it keyed by that index. The monitor compares the queued items on the falling edge of the matching cycle. An item that arrives one cycle early or late therefore shows up as a mismatch.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int unsigned ADDR_BITS  = 21;
    localparam int unsigned DATA_BITS  = 16;
    localparam int unsigned BLOCK_BITS = 6;
    localparam int unsigned WAIT_W     = 3;
    localparam int unsigned CNT_W      = WAIT_W + 1;

    localparam logic [WAIT_W-1:0] WAIT_MIN = 3'd4;
    localparam logic [WAIT_W-1:0] WAIT_RST = 3'd7;

    typedef enum logic [1:0] {
        CFG_WAIT  = 2'd0,
        CFG_PSAVE = 2'd1,
        CFG_CMD   = 2'd2,
        CFG_SPARE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [WAIT_W-1:0] wait_total;
        logic              psave;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_STREAM = 2'd2
    } phase_e;

    function automatic logic wait_legal(logic [WAIT_W-1:0] v);
        return v >= WAIT_MIN;
    endfunction

    function automatic logic [CNT_W-1:0] first_delay(cfg_t c);
        return {1'b0, c.wait_total} + {{(CNT_W-1){1'b0}}, c.psave};
    endfunction

endpackage

// File: rtl/bseq_cfg_regs.sv
module bseq_cfg_regs
    import bseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [WAIT_W-1:0] wdata,
    output cfg_t              cfg
);

    logic [WAIT_W-1:0] wait_q;
    logic              ps_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= WAIT_RST;
            ps_q   <= 1'b0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                CFG_WAIT: begin
                    if (wait_legal(wdata)) wait_q <= wdata;
                end
                CFG_PSAVE: begin
                    if (wdata[0]) ps_q <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    assign cfg.wait_total = wait_q;
    assign cfg.psave      = ps_q;

    // R6: illegal latency values never reach the register
    a_r6_wait_floor: assert property (@(posedge clk) disable iff (rst)
        wait_q >= WAIT_MIN);

    // R6: an out-of-range write leaves the setting unchanged
    a_r6_reject_low: assert property (@(posedge clk) disable iff (rst)
        (we && sel == 2'd0 && wdata < WAIT_MIN) |=> $stable(wait_q));

    // R7: power-save only clears through reset
    a_r7_psave_sticky: assert property (@(posedge clk) disable iff (rst)
        ps_q |=> ps_q);

endmodule

// File: rtl/bseq_addr_ctr.sv
module bseq_addr_ctr #(
    parameter int unsigned AW = bseq_pkg::ADDR_BITS,
    parameter int unsigned BW = bseq_pkg::BLOCK_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic          at_edge
);

    logic [AW-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else if (load) begin
            cur_q <= load_addr;
        end else if (step) begin
            cur_q <= cur_q + {{(AW-1){1'b0}}, 1'b1};
        end
    end

    assign cur_addr = cur_q;
    assign at_edge  = &cur_q[BW-1:0];

    // R5: stepping past the top address lands on zero
    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (step && !load && (&cur_q)) |=> (cur_q == '0));

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic chip_en_n,
    input  logic addr_strobe_n,
    input  cfg_t cfg,
    input  logic at_edge,
    output logic load,
    output logic step,
    output logic mem_rd,
    output logic rdy
);

    phase_e           phase_q;
    logic [CNT_W-1:0] wcnt_q;
    logic             gap_q;
    logic             burst_ps_q;
    logic             rdy_q;

    logic start;
    logic stop;
    logic issue;

    always_comb begin
        stop  = chip_en_n;
        start = !chip_en_n && !addr_strobe_n;
        unique case (phase_q)
            ST_WAIT:   issue = (wcnt_q == '0);
            ST_STREAM: issue = !gap_q;
            default:   issue = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= ST_IDLE;
            wcnt_q     <= '0;
            gap_q      <= 1'b0;
            burst_ps_q <= 1'b0;
            rdy_q      <= 1'b0;
        end else begin
            rdy_q <= issue && !stop && !start;
            if (stop) begin
                phase_q <= ST_IDLE;
                gap_q   <= 1'b0;
            end else if (start) begin
                phase_q    <= ST_WAIT;
                wcnt_q     <= first_delay(cfg) - {{(CNT_W-1){1'b0}}, 1'b1};
                burst_ps_q <= cfg.psave;
                gap_q      <= 1'b0;
            end else begin
                unique case (phase_q)
                    ST_WAIT: begin
                        if (wcnt_q == '0) begin
                            phase_q <= ST_STREAM;
                            gap_q   <= at_edge || burst_ps_q;
                        end else begin
                            wcnt_q <= wcnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
                        end
                    end
                    ST_STREAM: begin
                        if (gap_q) gap_q <= 1'b0;
                        else       gap_q <= at_edge;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign load   = start;
    assign step   = issue;
    assign mem_rd = issue;
    assign rdy    = rdy_q;

    // R2 / R9: a strobe is followed by a quiet cycle
    a_r2_strobe_quiet: assert property (@(posedge clk) disable iff (rst)
        (!chip_en_n && !addr_strobe_n) |=> (!rdy_q && !issue));

    // R8: deselect silences ready after the sampling edge
    a_r8_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        chip_en_n |=> !rdy_q);

    // R4: a read at a block end is followed by a gap cycle
    a_r4_block_gap: assert property (@(posedge clk) disable iff (rst)
        (issue && at_edge) |=> !issue);

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
    import bseq_pkg::*;
#(
    parameter int unsigned AW = ADDR_BITS,
    parameter int unsigned DW = DATA_BITS,
    parameter int unsigned BW = BLOCK_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chip_en_n,
    input  logic          addr_strobe_n,
    input  logic [AW-1:0] addr_in,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [2:0]    cfg_wdata,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          rdy,
    output logic [DW-1:0] dout
);

    cfg_t cfg;
    logic load;
    logic step;
    logic at_edge;

    bseq_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    bseq_addr_ctr #(.AW(AW), .BW(BW)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (addr_in),
        .step      (step),
        .cur_addr  (mem_addr),
        .at_edge   (at_edge)
    );

    bseq_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .chip_en_n     (chip_en_n),
        .addr_strobe_n (addr_strobe_n),
        .cfg           (cfg),
        .at_edge       (at_edge),
        .load          (load),
        .step          (step),
        .mem_rd        (mem_rd),
        .rdy           (rdy)
    );

    assign dout = mem_rdata;

    // R3: back-to-back reads walk consecutive addresses
    a_r3_consecutive: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + {{(AW-1){1'b0}}, 1'b1}));

    // R2: a presented word was requested on the cycle before
    a_r2_rdy_has_read: assert property (@(posedge clk) disable iff (rst)
        rdy |-> $past(mem_rd));

endmodule

// File: tb/burst_seq_top_bench.sv
`timescale 1ns/1ps
module burst_seq_top_bench;

    typedef struct {
        int          cyc;
        bit          rdy;
        logic [15:0] data;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chip_en_n = 1'b1;
    logic        addr_strobe_n = 1'b1;
    logic [20:0] addr_in = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [2:0]  cfg_wdata = '0;
    logic        mem_rd;
    logic [20:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        rdy;
    logic [15:0] dout;

    int    cyc = 0;
    int    n_checks = 0;
    int    n_err = 0;
    item_t sb[$];
    item_t mon_it;

    always #2 clk = ~clk;

    burst_seq_top u_burst_seq_top (
        .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .addr_strobe_n(addr_strobe_n),
        .addr_in(addr_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .rdy(rdy), .dout(dout)
    );

    function automatic logic [15:0] pattern(logic [20:0] a);
        return a[15:0] ^ 16'hA5C3 ^ {6'd0, a[20:16], 5'd0};
    endfunction

    // array model: one clock read latency
    always @(posedge clk) if (mem_rd) mem_rdata <= pattern(mem_addr);
    always @(posedge clk) cyc <= cyc + 1;

    function automatic void push(int c, bit r, logic [15:0] d, string t);
        item_t it;
        it.cyc = c; it.rdy = r; it.data = d; it.tag = t;
        sb.push_back(it);
    endfunction

    // expected ready/data pattern of one burst, slots before limit only
    function automatic int expect_burst(int e0, logic [20:0] start, int lat, bit ps,
                                        int n, int limit, string tag);
        int          t;
        int          last;
        logic [20:0] a;
        bit          bnd;
        a = start;
        last = e0;
        for (int j = 0; j < lat + int'(ps); j++)
            if (e0 + j < limit) push(e0 + j, 1'b0, 16'h0, tag);
        t = e0 + lat + int'(ps);
        for (int k = 0; k < n; k++) begin
            if (t >= limit) break;
            push(t, 1'b1, pattern(a), tag);
            last = t;
            bnd = (a[5:0] == 6'h3F);
            a = a + 21'd1;
            t++;
            if ((bnd || (k == 0 && ps)) && k < n - 1) begin
                if (t < limit) push(t, 1'b0, 16'h0, bnd ? "R4" : "R7");
                t++;
            end
        end
        return last;
    endfunction

    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            mon_it = sb.pop_front();
            n_checks++;
            if (mon_it.cyc != cyc || rdy !== mon_it.rdy ||
                (mon_it.rdy && dout !== mon_it.data)) begin
                n_err++;
                $display("FAIL %s cycle %0d: rdy=%0b dout=%h expected rdy=%0b dout=%h",
                         mon_it.tag, mon_it.cyc, rdy, dout, mon_it.rdy, mon_it.data);
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_slot(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic cfg_write(logic [1:0] s, logic [2:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // called at a falling edge; strobe is sampled at the next rising edge
    task automatic run_burst(logic [20:0] a, int lat, bit ps, int n, int lim_rel,
                             string tag, output int e0, output int last);
        chip_en_n = 1'b0; addr_strobe_n = 1'b0; addr_in = a;
        e0 = cyc + 1;
        last = expect_burst(e0, a, lat, ps, n, e0 + lim_rel, tag);
        @(negedge clk);
        addr_strobe_n = 1'b1;
    endtask

    task automatic end_burst(int last);
        wait_slot(last);
        chip_en_n = 1'b1;
        push(last + 1, 1'b0, 16'h0, "R8");
        push(last + 2, 1'b0, 16'h0, "R8");
        @(negedge clk);
        wait_slot(last + 4);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(rdy == 1'b0, "R1 rdy in reset", int'(rdy), 0);
        chk(mem_rd == 1'b0, "R1 mem_rd in reset", int'(mem_rd), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    localparam int BIG = 1000000;

    initial begin
        int e0;
        int last;
        int e1;
        @(negedge clk);
        do_reset();

        // R1 default latency 7, R2 first word timing, R3 sequence
        run_burst(21'h00010, 7, 1'b0, 8, BIG, "R2", e0, last);
        end_burst(last);

        // R4: crossing a 64-word block
        run_burst(21'h0003C, 7, 1'b0, 8, BIG, "R4", e0, last);
        end_burst(last);

        // R6 accepted value, R5 top-of-array wrap
        cfg_write(2'd0, 3'd4);
        run_burst(21'h1FFFFD, 4, 1'b0, 6, BIG, "R5", e0, last);
        end_burst(last);

        // R6 rejected values keep latency 4
        cfg_write(2'd0, 3'd2);
        cfg_write(2'd0, 3'd0);
        run_burst(21'h00100, 4, 1'b0, 3, BIG, "R6", e0, last);
        end_burst(last);

        // R10: writes during a burst leave it intact
        run_burst(21'h00200, 4, 1'b0, 12, BIG, "R10", e0, last);
        wait_slot(e0 + 6);
        cfg_write(2'd2, 3'd7);
        cfg_write(2'd0, 3'd6);
        cfg_write(2'd3, 3'd5);
        end_burst(last);

        // R9: restart mid-burst with the new latency 6
        run_burst(21'h00300, 6, 1'b0, 20, 9, "R9", e0, last);
        wait_slot(e0 + 8);
        run_burst(21'h05000, 6, 1'b0, 5, BIG, "R9", e1, last);
        chk(e1 == e0 + 9, "R9 restart edge", e1, e0 + 9);
        end_burst(last);

        // R7: a write of zero does not enable power-save
        cfg_write(2'd1, 3'd0);
        run_burst(21'h00020, 6, 1'b0, 3, BIG, "R7", e0, last);
        end_burst(last);

        // R7: power-save startup cycles
        cfg_write(2'd1, 3'd1);
        run_burst(21'h00400, 6, 1'b1, 5, BIG, "R7", e0, last);
        end_burst(last);

        // R7 with R4 at the same step: single stall
        run_burst(21'h0043F, 6, 1'b1, 4, BIG, "R7", e0, last);
        end_burst(last);

        // R7: power-save survives a write of zero
        cfg_write(2'd1, 3'd0);
        run_burst(21'h00800, 6, 1'b1, 3, BIG, "R7", e0, last);
        end_burst(last);

        // R1: reset restores latency 7 and clears power-save
        do_reset();
        run_burst(21'h00010, 7, 1'b0, 3, BIG, "R1", e0, last);
        end_burst(last);

        // R8: strobe while deselected starts nothing
        addr_strobe_n = 1'b0; addr_in = 21'h00050;
        e0 = cyc + 1;
        for (int j = 0; j < 10; j++) push(e0 + j, 1'b0, 16'h0, "R8");
        @(negedge clk);
        addr_strobe_n = 1'b1;
        for (int j = 0; j < 10; j++) begin
            chk(mem_rd == 1'b0, "R8 no read while deselected", int'(mem_rd), 0);
            @(negedge clk);
        end
        wait_slot(e0 + 12);

        chk(sb.size() == 0, "R3 all expected items seen", sb.size(), 0);
        summary();
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        summary();
        $finish;
    end

endmodule